// File: doc/BRIEF.md
# Banked Differential Gamma Correction Stage

This block applies a per-channel gamma curve to a stream of 10-bit RGB pixels. Each incoming channel value selects one of 1024 table entries, and the top 10 bits of the 12-bit entry become the output channel. Software loads the table through a small byte-addressed register port. A bank register picks one of four 256-entry pages. Two word windows carry the entry data, with red and green in one window and blue in the other. An older single-word packing that holds three 10-bit fields is also accepted.

A differential option lets odd table entries hold a signed-free delta, added modulo 4096 to the even entry just below them when the entry is read. Pixels move under valid/ready flow control with a fixed two-cycle latency. The stage counts pixels against a programmed frame size to mark the last pixel of each row and of each frame. Global enable, relay, table enable, differential mode and frame size are captured only on the first pixel of a frame. A frame therefore never mixes two setups.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the enable, configuration, size and bank registers all read back as 0.
- R2: Registers read back at their byte offsets: enable bit 0 at 0x000; configuration at 0x020 with relay in bit 0, table enable in bit 1, table type in bit 2 and differential mode in bit 3; size at 0x030 with width in [28:16] and height in [12:0]; bank at 0x100 with page in [1:0] and 12-bit data mode in bit 2.
- R3: With bank bit 2 set, a write to 0x700 + 4·k stores red from [11:0] and green from [23:12] into entry page·256 + k. A write to 0xB00 + 4·k stores blue from [11:0] into that same entry.
- R4: With bank bit 2 clear, a write to 0x700 + 4·k stores red from [29:20], green from [19:10] and blue from [9:0], each shifted left by 2, into entry page·256 + k. Writes to 0xB00 + 4·k have no effect in this mode.
- R5: When enable is 1, relay is 0, table enable is 1 and differential mode is 0, each output channel is bits [11:2] of the entry indexed by that input channel.
- R6: In differential mode, an odd input value i yields bits [11:2] of (entry[i-1] + entry[i]) mod 4096. An even value yields bits [11:2] of entry[i].
- R7: When enable is 0, relay is 1, or table enable is 0, the output pixel equals the input pixel.
- R8: With out_ready held high, a pixel accepted at a clock edge appears on the outputs with out_valid high after the following edge, which is two cycles later.
- R9: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low. No pixel is lost or duplicated.
- R10: out_eol marks the last pixel of each row of the captured width. out_eof marks the last pixel of the last row of the captured height, and it is only ever set together with out_eol.
- R11: Writes to enable, configuration or size made during a frame do not affect the rest of that frame. They take effect from the next frame's first pixel.
- R12: The table-type bit is stored and read back but does not change the output pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_r | input | 10 | Input red |
| in_g | input | 10 | Input green |
| in_b | input | 10 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_r | output | 10 | Output red |
| out_g | output | 10 | Output green |
| out_b | output | 10 | Output blue |
| out_eol | output | 1 | Last pixel of a row |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The hardest case to reach is a setup change that lands partway through a frame while the output is stalled. The stage must keep using the captured setup for the rest of that frame and switch exactly at the next frame's first pixel. The stimulus writes the configuration and size registers between pixels of a running frame while out_ready toggles at random. A second hard case is the 10-bit packing on a page other than zero, where the blue window has to be ignored. It is reached by switching the bank register to page 2 with the data-mode bit clear, then sending pixels whose channel values index exactly the rewritten entries.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SIZE_W = 13;

    // Byte offsets of the register port
    localparam logic [ADDR_W-1:0] OFS_EN   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_BANK = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_WIN0 = 12'h700;
    localparam logic [ADDR_W-1:0] OFS_WIN1 = 12'hB00;

    // Configuration bit positions
    localparam int unsigned CFG_RELAY = 0;
    localparam int unsigned CFG_LUT   = 1;
    localparam int unsigned CFG_TYPE  = 2;
    localparam int unsigned CFG_DIFF  = 3;

    // Bank register bit selecting the two-window 12-bit layout
    localparam int unsigned BANK_WIDE_BIT = 2;

    // Setup that is captured once per frame
    typedef struct packed {
        logic              en;
        logic              relay;
        logic              lut_en;
        logic              diff;
        logic [SIZE_W-1:0] hsize;
        logic [SIZE_W-1:0] vsize;
    } frame_cfg_t;

endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
    import gamma_pkg::*;
#(
    parameter int CH_W       = 10,
    parameter int LUT_W      = 12,
    parameter int BANK_DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output frame_cfg_t                 cfg,
    output logic [2:0]                 tab_we,
    output logic [CH_W-1:0]            tab_idx,
    output logic [2:0][LUT_W-1:0]      tab_wd
);
    localparam int DEPTH     = 2 ** CH_W;
    localparam int NUM_BANKS = DEPTH / BANK_DEPTH;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int OFS_W     = $clog2(BANK_DEPTH);
    localparam int SHIFT     = LUT_W - CH_W;
    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(4 * BANK_DEPTH);

    typedef struct packed {
        logic              en;
        logic [3:0]        cfg;
        logic [SIZE_W-1:0] hs;
        logic [SIZE_W-1:0] vs;
        logic [BANK_W-1:0] bank;
        logic              wide;
    } regs_t;

    regs_t st_d, st_q;

    logic [ADDR_W-1:0] off0, off1;
    logic              hit0, hit1;
    logic              unused_bits;

    assign off0 = addr - OFS_WIN0;
    assign off1 = addr - OFS_WIN1;
    assign hit0 = wr && (addr >= OFS_WIN0) && (off0 < WIN_SPAN) && (addr[1:0] == 2'b00);
    assign hit1 = wr && (addr >= OFS_WIN1) && (off1 < WIN_SPAN) && (addr[1:0] == 2'b00);
    assign unused_bits = ^{wdata[DATA_W-1:30], off0, off1};

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (addr)
                OFS_EN:   st_d.en = wdata[0];
                OFS_CFG:  st_d.cfg = wdata[3:0];
                OFS_SIZE: begin
                    st_d.hs = wdata[16 +: SIZE_W];
                    st_d.vs = wdata[0 +: SIZE_W];
                end
                OFS_BANK: begin
                    st_d.bank = wdata[BANK_W-1:0];
                    st_d.wide = wdata[BANK_WIDE_BIT];
                end
                default: ;
            endcase
        end
    end

    // Table write port
    always_comb begin
        tab_idx = {st_q.bank, (hit0 ? off0[OFS_W+1:2] : off1[OFS_W+1:2])};
        if (st_q.wide) begin
            tab_we    = {hit0, hit0, hit1};
            tab_wd[2] = wdata[LUT_W-1:0];
            tab_wd[1] = wdata[2*LUT_W-1:LUT_W];
            tab_wd[0] = wdata[LUT_W-1:0];
        end else begin
            tab_we    = {hit0, hit0, hit0};
            tab_wd[2] = {wdata[3*CH_W-1:2*CH_W], {SHIFT{1'b0}}};
            tab_wd[1] = {wdata[2*CH_W-1:CH_W],   {SHIFT{1'b0}}};
            tab_wd[0] = {wdata[CH_W-1:0],        {SHIFT{1'b0}}};
        end
    end

    // Readback
    always_comb begin
        case (addr)
            OFS_EN:   rdata = DATA_W'(st_q.en);
            OFS_CFG:  rdata = DATA_W'(st_q.cfg);
            OFS_SIZE: rdata = DATA_W'({st_q.hs, 3'b000, st_q.vs});
            OFS_BANK: rdata = DATA_W'({st_q.wide, st_q.bank});
            default:  rdata = '0;
        endcase
    end

    assign cfg.en     = st_q.en;
    assign cfg.relay  = st_q.cfg[CFG_RELAY];
    assign cfg.lut_en = st_q.cfg[CFG_LUT];
    assign cfg.diff   = st_q.cfg[CFG_DIFF];
    assign cfg.hsize  = st_q.hs;
    assign cfg.vsize  = st_q.vs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gamma_table.sv
module gamma_table #(
    parameter int CH_W  = 10,
    parameter int LUT_W = 12
) (
    input  logic                  clk,
    input  logic [2:0]            we,
    input  logic [CH_W-1:0]       widx,
    input  logic [2:0][LUT_W-1:0] wd,
    input  logic [2:0][CH_W-1:0]  rd_idx,
    input  logic                  rd_diff,
    output logic [2:0][LUT_W-1:0] rd_val
);
    localparam int DEPTH = 2 ** CH_W;

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        logic [LUT_W-1:0] mem [DEPTH];
        logic [LUT_W-1:0] base_v, self_v;
        logic [CH_W-1:0]  even_idx;

        always_ff @(posedge clk) begin
            if (we[ch]) mem[widx] <= wd[ch];
        end

        assign even_idx = {rd_idx[ch][CH_W-1:1], 1'b0};
        assign base_v   = mem[even_idx];
        assign self_v   = mem[rd_idx[ch]];
        assign rd_val[ch] = (rd_diff && rd_idx[ch][0]) ? (base_v + self_v) : self_v;
    end

endmodule

// File: rtl/gamma_pipe.sv
module gamma_pipe
    import gamma_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int LUT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  frame_cfg_t            cfg,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2:0][CH_W-1:0]  in_pix,
    output logic [2:0][CH_W-1:0]  rd_idx,
    output logic                  rd_diff,
    input  logic [2:0][LUT_W-1:0] look,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [2:0][CH_W-1:0]  out_pix,
    output logic                  out_eol,
    output logic                  out_eof
);
    typedef struct packed {
        frame_cfg_t          act;
        logic [SIZE_W-1:0]   x;
        logic [SIZE_W-1:0]   y;
        logic                v1;
        logic [2:0][CH_W-1:0] p1;
        logic                pass1;
        logic                diff1;
        logic                eol1;
        logic                eof1;
        logic                v2;
        logic [2:0][CH_W-1:0] p2;
        logic                eol2;
        logic                eof2;
    } pipe_t;

    pipe_t      st_d, st_q;
    frame_cfg_t use_cfg;
    logic       adv, fs, acc, last_x, last_y;
    logic       unused_look;

    assign unused_look = ^look;

    always_comb begin
        adv     = !st_q.v2 || out_ready;
        fs      = (st_q.x == '0) && (st_q.y == '0);
        use_cfg = fs ? cfg : st_q.act;
        acc     = in_valid && adv;
        last_x  = ({1'b0, st_q.x} + 1'b1) >= {1'b0, use_cfg.hsize};
        last_y  = ({1'b0, st_q.y} + 1'b1) >= {1'b0, use_cfg.vsize};

        st_d = st_q;
        if (adv) begin
            st_d.v2   = st_q.v1;
            st_d.eol2 = st_q.eol1;
            st_d.eof2 = st_q.eof1;
            for (int c = 0; c < 3; c++) begin
                st_d.p2[c] = st_q.pass1 ? st_q.p1[c] : look[c][LUT_W-1 -: CH_W];
            end
            st_d.v1 = in_valid;
            if (in_valid) begin
                st_d.p1    = in_pix;
                st_d.pass1 = !use_cfg.en || use_cfg.relay || !use_cfg.lut_en;
                st_d.diff1 = use_cfg.diff;
                st_d.eol1  = last_x;
                st_d.eof1  = last_x && last_y;
            end
        end

        if (acc) begin
            if (fs) st_d.act = cfg;
            if (last_x) begin
                st_d.x = '0;
                st_d.y = last_y ? '0 : st_q.y + 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
    end

    assign in_ready  = adv;
    assign rd_idx    = st_q.p1;
    assign rd_diff   = st_q.diff1;
    assign out_valid = st_q.v2;
    assign out_pix   = st_q.p2;
    assign out_eol   = st_q.eol2;
    assign out_eof   = st_q.eof2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_pkg::*;
#(
    parameter int CH_W       = 10,
    parameter int LUT_W      = 12,
    parameter int BANK_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CH_W-1:0]   in_r,
    input  logic [CH_W-1:0]   in_g,
    input  logic [CH_W-1:0]   in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CH_W-1:0]   out_r,
    output logic [CH_W-1:0]   out_g,
    output logic [CH_W-1:0]   out_b,
    output logic              out_eol,
    output logic              out_eof
);
    frame_cfg_t            cfg;
    logic [2:0]            tab_we;
    logic [CH_W-1:0]       tab_idx;
    logic [2:0][LUT_W-1:0] tab_wd;
    logic [2:0][CH_W-1:0]  rd_idx;
    logic                  rd_diff;
    logic [2:0][LUT_W-1:0] look;
    logic [2:0][CH_W-1:0]  in_pix, out_pix;

    assign in_pix = {in_r, in_g, in_b};
    assign out_r  = out_pix[2];
    assign out_g  = out_pix[1];
    assign out_b  = out_pix[0];

    gamma_regs #(.CH_W(CH_W), .LUT_W(LUT_W), .BANK_DEPTH(BANK_DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .cfg(cfg), .tab_we(tab_we), .tab_idx(tab_idx), .tab_wd(tab_wd)
    );

    gamma_table #(.CH_W(CH_W), .LUT_W(LUT_W)) u_table (
        .clk(clk), .we(tab_we), .widx(tab_idx), .wd(tab_wd),
        .rd_idx(rd_idx), .rd_diff(rd_diff), .rd_val(look)
    );

    gamma_pipe #(.CH_W(CH_W), .LUT_W(LUT_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .rd_idx(rd_idx), .rd_diff(rd_diff), .look(look),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_eol(out_eol), .out_eof(out_eof)
    );

endmodule

// File: rtl/gamma_lut_stage_chk.sv
module gamma_lut_stage_chk
    import gamma_pkg::*;
#(
    parameter int CH_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [11:0]     reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [31:0]     reg_rdata,
    input logic            in_valid,
    input logic            in_ready,
    input logic [CH_W-1:0] in_r,
    input logic [CH_W-1:0] in_g,
    input logic [CH_W-1:0] in_b,
    input logic            out_valid,
    input logic            out_ready,
    input logic [CH_W-1:0] out_r,
    input logic [CH_W-1:0] out_g,
    input logic [CH_W-1:0] out_b,
    input logic            out_eol,
    input logic            out_eof
);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g)
                                       && $stable(out_b) && $stable(out_eol) && $stable(out_eof)));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r10_eof_with_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> out_eol);

    a_r2_cfg_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr && reg_addr == OFS_CFG) ##1 (reg_addr == OFS_CFG))
            |-> (reg_rdata[3:0] == $past(reg_wdata[3:0])));

    a_r2_bank_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr && reg_addr == OFS_BANK) ##1 (reg_addr == OFS_BANK))
            |-> (reg_rdata[2:0] == $past(reg_wdata[2:0])));

endmodule

bind gamma_lut_stage gamma_lut_stage_chk #(.CH_W(CH_W)) u_chk (.*);

// File: tb/gamma_lut_stage_test.sv
module gamma_lut_stage_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        in_valid, in_ready, out_valid, out_ready, out_eol, out_eof;
    logic [9:0]  in_r, in_g, in_b, out_r, out_g, out_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gamma_lut_stage uut (.*);

    typedef struct packed {
        logic [29:0] pix;
        logic        eol;
        logic        eof;
        logic [31:0] tag;
        logic [31:0] cyc;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    int   tab[3][1024];
    bit   m_en, m_wide;
    bit [3:0]  m_cfg, a_cfg;
    bit [12:0] m_h, m_v, a_h, a_v;
    bit [1:0]  m_bank;
    bit        a_en;
    int   bx = 0, by = 0;
    int   cur_tag = 0;
    bit   force_rdy = 0, lat_chk = 0;

    function automatic string tname(int t);
        case (t)
            3: return "R3"; 4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; 11: return "R11"; 12: return "R12";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic int look(int ch, int idx, bit diff);
        int v = tab[ch][idx];
        if (diff && idx[0]) v = (tab[ch][idx-1] + tab[ch][idx]) & 12'hFFF;
        return v >> 2;
    endfunction

    // Bench model of register writes (R2, R3, R4)
    task automatic model_write(bit [11:0] a, bit [31:0] d);
        int k;
        if (a == 12'h000) m_en = d[0];
        else if (a == 12'h020) m_cfg = d[3:0];
        else if (a == 12'h030) begin m_h = d[28:16]; m_v = d[12:0]; end
        else if (a == 12'h100) begin m_bank = d[1:0]; m_wide = d[2]; end
        else if (a >= 12'h700 && a < 12'hB00 && a[1:0] == 0) begin
            k = m_bank * 256 + (a - 12'h700) / 4;
            if (m_wide) begin tab[0][k] = d[11:0]; tab[1][k] = d[23:12]; end
            else begin
                tab[0][k] = d[29:20] << 2; tab[1][k] = d[19:10] << 2; tab[2][k] = d[9:0] << 2;
            end
        end else if (a >= 12'hB00 && a < 12'hF00 && a[1:0] == 0) begin
            k = m_bank * 256 + (a - 12'hB00) / 4;
            if (m_wide) tab[2][k] = d[11:0];
        end
    endtask

    // Bench model of pixel acceptance (R5..R11)
    task automatic model_accept(bit [29:0] p);
        exp_t e;
        bit pass, lx, ly;
        int ch_in[3];
        if (bx == 0 && by == 0) begin
            a_en = m_en; a_cfg = m_cfg; a_h = m_h; a_v = m_v;
        end
        lx = (bx + 1) >= a_h;
        ly = (by + 1) >= a_v;
        ch_in[0] = p[29:20]; ch_in[1] = p[19:10]; ch_in[2] = p[9:0];
        pass = !a_en || a_cfg[0] || !a_cfg[1];
        if (pass) e.pix = p;
        else e.pix = {10'(look(0, ch_in[0], a_cfg[3])), 10'(look(1, ch_in[1], a_cfg[3])),
                      10'(look(2, ch_in[2], a_cfg[3]))};
        e.eol = lx;
        e.eof = lx && ly;
        e.tag = cur_tag != 0 ? cur_tag : (pass ? 7 : (a_cfg[3] ? 6 : 5));
        e.cyc = cyc;
        exp_q.push_back(e);
        if (lx) begin bx = 0; by = ly ? 0 : by + 1; end
        else bx++;
    endtask

    task automatic step(bit pv, bit [29:0] pp, bit wv, bit [11:0] wa, bit [31:0] wd, output bit acc);
        exp_t e;
        in_valid = pv; {in_r, in_g, in_b} = pp;
        reg_wr = wv; reg_addr = wa; reg_wdata = wd;
        out_ready = force_rdy ? 1'b1 : (($urandom % 4) != 0);
        #1;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(0, "R9", "unexpected pixel", {out_r, out_g, out_b}, 0);
            else begin
                e = exp_q.pop_front();
                chk({out_r, out_g, out_b} == e.pix, tname(e.tag), "pixel", {out_r, out_g, out_b}, e.pix);
                chk({out_eol, out_eof} == {e.eol, e.eof}, "R10", "eol/eof", {out_eol, out_eof}, {e.eol, e.eof});
                if (lat_chk) chk(cyc - e.cyc == 2, "R8", "latency", cyc - e.cyc, 2);
            end
        end
        acc = pv && in_ready;
        if (acc) model_accept(pp);
        if (wv) model_write(wa, wd);
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr(bit [11:0] a, bit [31:0] d);
        bit acc;
        step(0, '0, 1, a, d, acc);
    endtask

    task automatic send(bit [29:0] p);
        bit acc = 0;
        while (!acc) step(1, p, 0, '0, '0, acc);
    endtask

    task automatic drain();
        bit acc;
        int guard = 0;
        while (exp_q.size() != 0 && guard < 1000) begin step(0, '0, 0, '0, '0, acc); guard++; end
        step(0, '0, 0, '0, '0, acc);
    endtask

    task automatic rd(bit [11:0] a, bit [31:0] expv, string tag);
        reg_wr = 0; in_valid = 0; out_ready = 1; reg_addr = a;
        #1;
        chk(reg_rdata == expv, tag, "readback", reg_rdata, expv);
        @(negedge clk);
        cyc++;
    endtask

    task automatic frame(int h, int v, int tag);
        cur_tag = tag;
        wr(12'h030, {3'b0, 13'(h), 3'b0, 13'(v)});
        for (int i = 0; i < h * v; i++) send(30'($urandom));
        drain();
        cur_tag = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        in_valid = 0; in_r = 0; in_g = 0; in_b = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
        chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
        rd(12'h000, 0, "R1"); rd(12'h020, 0, "R1"); rd(12'h030, 0, "R1"); rd(12'h100, 0, "R1");

        // R2 readback
        wr(12'h000, 1); rd(12'h000, 1, "R2");
        wr(12'h020, 32'hFFFF_FFFA); rd(12'h020, 32'hA, "R2");
        wr(12'h030, {3'b111, 13'h1ABC, 3'b111, 13'h0123}); rd(12'h030, {3'b0, 13'h1ABC, 3'b0, 13'h0123}, "R2");
        wr(12'h100, 32'hFFFF_FFFD); rd(12'h100, 32'h5, "R2");

        // R3 fill full table in 12-bit layout
        for (int b = 0; b < 4; b++) begin
            wr(12'h100, 32'(4 | b));
            for (int i = 0; i < 256; i++) begin
                wr(12'(12'h700 + 4 * i), $urandom);
                wr(12'(12'hB00 + 4 * i), $urandom);
            end
        end

        wr(12'h020, 32'h2);
        frame(6, 3, 3);
        frame(7, 2, 5);
        wr(12'h020, 32'hA);
        frame(8, 3, 6);
        frame(5, 4, 6);
        // R7 passthrough variants
        wr(12'h020, 32'h3); frame(4, 2, 7);
        wr(12'h020, 32'h0); frame(4, 2, 7);
        wr(12'h020, 32'h2); wr(12'h000, 0); frame(4, 2, 7); wr(12'h000, 1);
        // R12 table-type bit
        wr(12'h020, 32'h6); rd(12'h020, 32'h6, "R12"); frame(6, 2, 12);
        // R8 latency without backpressure
        wr(12'h020, 32'h2);
        force_rdy = 1; lat_chk = 1; frame(5, 2, 8); force_rdy = 0; lat_chk = 0;

        // R11 mid-frame changes wait for the next frame
        cur_tag = 11;
        wr(12'h030, {3'b0, 13'd4, 3'b0, 13'd2});
        for (int i = 0; i < 3; i++) send(30'($urandom));
        wr(12'h020, 32'h3);
        wr(12'h030, {3'b0, 13'd3, 3'b0, 13'd2});
        for (int i = 0; i < 5; i++) send(30'($urandom));
        for (int i = 0; i < 6; i++) send(30'($urandom));
        drain();
        cur_tag = 0;

        // R4 10-bit packing on page 2, blue window ignored
        wr(12'h100, 32'h2);
        for (int k = 0; k < 8; k++) wr(12'(12'h700 + 4 * k), $urandom);
        for (int k = 0; k < 8; k++) wr(12'(12'hB00 + 4 * k), $urandom);
        wr(12'h020, 32'h2);
        cur_tag = 4;
        wr(12'h030, {3'b0, 13'd8, 3'b0, 13'd1});
        for (int k = 0; k < 8; k++) begin
            bit [9:0] i0 = 10'(512 + k);
            bit [9:0] i1 = 10'(512 + (k + 3) % 8);
            bit [9:0] i2 = 10'(512 + (7 - k));
            send({i0, i1, i2});
        end
        drain();
        wr(12'h020, 32'hA); frame(8, 1, 4);
        cur_tag = 0;

        // Random setups and sizes
        for (int f = 0; f < 6; f++) begin
            wr(12'h020, 32'($urandom % 16));
            frame(1 + $urandom % 9, 1 + $urandom % 4, 0);
        end

        drain();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule